// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It fetches from an instruction memory through an address output and an instruction input. It reaches a data memory through an address, write data, a write strobe and read data. Each data memory read is combinational. The core supports six data-processing operations (and, sub, add, orr, mov and cmp), word loads and stores, and two branches, one of which saves a return address.

Inside the core are the program counter, a sixteen-entry register file, immediate extension, an adder/logic unit and the writeback selection. The register file has three read ports. The third read port supplies the value to be stored, and its address comes from the destination field on stores and from the Rm field otherwise. Register 15 is not stored: reading it returns the address of the current instruction plus 8.

The core does not support conditional execution, so the flags written by cmp are exported for observation only. Bits [31:28] of each instruction are ignored.

Top module: `sc_core`

## Requirements
- R1: While reset is held, the instruction address is RESET_PC (default 0). After reset, the address grows by 4 on each clock edge that completes a non-branch instruction.
- R2: The register fields are Rd = instr[15:12], Rn = instr[19:16] and Rm = instr[3:0]. A register write takes effect on the rising edge. Reset clears R0 to R14. A write whose target is register 15 is discarded, and the PC then advances normally.
- R3: Data processing uses instr[27:26]=00. The second operand is Rm when instr[25]=0, or the zero-extended instr[7:0] when instr[25]=1. The operation code in instr[24:21] selects: 0000 and, 0010 sub (Rn minus operand), 0100 add, 1100 orr, 1101 mov (operand). The result goes to Rd.
- R4: Code 1010 in instr[24:21] is cmp. It computes Rn minus operand and sets the flags output {N,Z,C,V}, which are bits 3 to 0, with C=1 meaning no borrow. It writes no register. No other instruction changes the flags, and reset clears them.
- R5: A register read of number 15 returns the current instruction address plus 8.
- R6: A load uses instr[27:26]=01 with instr[20]=1. Its address is Rn plus the zero-extended instr[11:0] when instr[25]=0, or Rn plus Rm when instr[25]=1. The word read from that address is written to Rd.
- R7: A store uses instr[27:26]=01 with instr[20]=0. It has the same two address forms as a load. It drives the Rd value on the write data, and the write strobe is high for that cycle only.
- R8: A branch uses instr[27:26]=10. The next address is (current address + 8) + sign_extend(instr[23:0]) × 4, and both forward and backward targets are allowed.
- R9: A branch with instr[24]=1 also writes the current address plus 4 into R14 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Address of the current instruction |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 32 | Load data at dmem_addr, combinational |
| nzcv | output | 4 | Flags from the latest cmp: N, Z, C, V |

## Verification
The bench builds the core with its default RESET_PC of zero. This places the programs at address 0 of a small word array that the bench indexes by address bits [7:2], so every branch target and link value can be worked out by hand. Each scenario loads a short program that ends in a branch to itself and writes its results to data memory. The bench compares those words with values derived by hand from the requirements. The scenarios cover wrap-around subtraction, both operand forms of loads and stores, the R15 read offset, and the four flag cases, including signed overflow from 0x80000000.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int NREGS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic [3:0]  nzcv
);
  localparam int AW = $clog2(NREGS);
  localparam logic [AW-1:0] PC_IDX = AW'(NREGS - 1);
  localparam logic [AW-1:0] LR_IDX = AW'(NREGS - 2);

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_SUB = 4'b0010;
  localparam logic [3:0] OP_ADD = 4'b0100;
  localparam logic [3:0] OP_CMP = 4'b1010;
  localparam logic [3:0] OP_ORR = 4'b1100;
  localparam logic [3:0] OP_MOV = 4'b1101;

  logic [31:0] pc, pc_plus4, pc_plus8;
  logic [31:0] rf [NREGS];
  logic [31:0] instr;

  assign instr     = imem_rdata;
  assign imem_addr = pc;
  assign pc_plus4  = pc + 32'd4;
  assign pc_plus8  = pc + 32'd8;

  logic unused_cond;
  assign unused_cond = ^instr[31:28];

  logic [AW-1:0] rd_a, rn_a, rm_a, rc_a;
  logic [3:0]    opc;
  logic          is_dp, is_mem, is_br, use_imm, is_load, is_store, is_cmp, is_bl;

  assign rd_a     = instr[15:12];
  assign rn_a     = instr[19:16];
  assign rm_a     = instr[3:0];
  assign opc      = instr[24:21];
  assign use_imm  = instr[25];
  assign is_dp    = instr[27:26] == 2'b00;
  assign is_mem   = instr[27:26] == 2'b01;
  assign is_br    = instr[27:26] == 2'b10;
  assign is_load  = is_mem & instr[20];
  assign is_store = is_mem & ~instr[20];
  assign is_cmp   = is_dp & (opc == OP_CMP);
  assign is_bl    = is_br & instr[24];

  // third read port: Rd for stores, Rm otherwise
  assign rc_a = is_store ? rd_a : rm_a;

  logic [31:0] rn_v, rm_v, rc_v;
  assign rn_v = (rn_a == PC_IDX) ? pc_plus8 : rf[rn_a];
  assign rm_v = (rm_a == PC_IDX) ? pc_plus8 : rf[rm_a];
  assign rc_v = (rc_a == PC_IDX) ? pc_plus8 : rf[rc_a];

  logic [31:0] op2;
  always_comb begin
    if (is_dp) op2 = use_imm ? {24'b0, instr[7:0]} : rm_v;
    else       op2 = use_imm ? rm_v : {20'b0, instr[11:0]};
  end

  logic [32:0] diff;
  logic [31:0] alu_res;
  logic        dp_wr;
  assign diff = {1'b0, rn_v} - {1'b0, op2};

  always_comb begin
    alu_res = rn_v + op2;
    dp_wr   = 1'b0;
    if (is_dp) begin
      unique case (opc)
        OP_AND:  begin alu_res = rn_v & op2;  dp_wr = 1'b1; end
        OP_SUB:  begin alu_res = diff[31:0];  dp_wr = 1'b1; end
        OP_ADD:  begin alu_res = rn_v + op2;  dp_wr = 1'b1; end
        OP_ORR:  begin alu_res = rn_v | op2;  dp_wr = 1'b1; end
        OP_MOV:  begin alu_res = op2;         dp_wr = 1'b1; end
        OP_CMP:  alu_res = diff[31:0];
        default: alu_res = rn_v + op2;
      endcase
    end
  end

  assign dmem_addr  = alu_res;
  assign dmem_wdata = rc_v;
  assign dmem_we    = is_store;

  logic [AW-1:0] wb_a;
  logic [31:0]   wb_d;
  logic          wb_en;
  assign wb_a  = is_bl ? LR_IDX : rd_a;
  assign wb_d  = is_load ? dmem_rdata : (is_bl ? pc_plus4 : alu_res);
  assign wb_en = (dp_wr | is_load | is_bl) & (wb_a != PC_IDX);

  logic [31:0] br_target, pc_next;
  assign br_target = pc_plus8 + {{6{instr[23]}}, instr[23:0], 2'b00};
  assign pc_next   = is_br ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (wb_en) begin
      rf[wb_a] <= wb_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      nzcv <= 4'b0000;
    else if (is_cmp) nzcv <= {diff[31], diff[31:0] == 32'd0, ~diff[32],
                              (rn_v[31] ^ op2[31]) & (diff[31] ^ rn_v[31])};
  end

  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(is_br) |-> imem_addr == $past(imem_addr) + 32'd4);

  // R8
  br_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_br) |-> imem_addr == $past(br_target));

  // R9
  link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_bl) |-> rf[LR_IDX] == $past(imem_addr) + 32'd4);

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(is_cmp) |-> $stable(nzcv));

  // R4
  z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_cmp) |-> nzcv[2] == ($past(rn_v) == $past(op2)));
endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  logic [3:0] nzcv;
  int errors = 0;
  int checks = 0;

  logic [31:0] im [64];
  logic [31:0] dm [64];

  always #2.5 clk = ~clk;

  sc_core dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .nzcv(nzcv)
  );

  assign imem_rdata = im[imem_addr[7:2]];
  assign dmem_rdata = dm[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:2]] = dmem_wdata;

  localparam logic [3:0] AND_ = 4'b0000, SUB_ = 4'b0010, ADD_ = 4'b0100;
  localparam logic [3:0] CMP_ = 4'b1010, ORR_ = 4'b1100, MOV_ = 4'b1101;
  localparam logic [31:0] HALT = {4'hE, 4'b1010, 24'hFFFFFE};

  function automatic logic [31:0] dp(input logic [3:0] op, input logic imm,
                                     input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [7:0] v);
    return {4'hE, 2'b00, imm, op, 1'b0, rn, rd, 4'h0, v};
  endfunction

  function automatic logic [31:0] ls(input logic ld, input logic regoff,
                                     input logic [3:0] rn, input logic [3:0] rd,
                                     input logic [11:0] off);
    return {4'hE, 2'b01, regoff, 4'b1100, ld, rn, rd, off};
  endfunction

  function automatic logic [31:0] br(input logic link, input logic [23:0] off);
    return {4'hE, 3'b101, link, off};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      im[i] = HALT;
      dm[i] = 32'hA5A5_A5A5;
    end
  endtask

  task automatic start();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    clear_mem();
    im[0] = dp(MOV_, 1, 0, 1, 8'd3);
    im[1] = dp(MOV_, 1, 0, 15, 8'd0);
    im[2] = ls(0, 0, 0, 1, 12'd0);
    rst_n = 1'b0;
    step(2);
    chk(imem_addr, 32'h0, "R1 pc in reset");
    chk({28'b0, nzcv}, 32'h0, "R4 flags in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1);
    chk(imem_addr, 32'd4, "R1 pc step");
    step(1);
    chk(imem_addr, 32'd8, "R2 write to r15 discarded");
    step(5);
    chk(dm[0], 32'd3, "R2 mov r1 stored");
  endtask

  task automatic t_alu();
    clear_mem();
    im[0]  = dp(MOV_, 1, 0, 1, 8'd200);
    im[1]  = dp(MOV_, 1, 0, 2, 8'd55);
    im[2]  = dp(ADD_, 0, 1, 3, 8'd2);
    im[3]  = dp(SUB_, 0, 1, 4, 8'd2);
    im[4]  = dp(AND_, 1, 1, 5, 8'h0F);
    im[5]  = dp(ORR_, 0, 2, 6, 8'd1);
    im[6]  = dp(SUB_, 0, 2, 7, 8'd1);
    im[7]  = ls(0, 0, 0, 3, 12'd0);
    im[8]  = ls(0, 0, 0, 4, 12'd4);
    im[9]  = ls(0, 0, 0, 5, 12'd8);
    im[10] = ls(0, 0, 0, 6, 12'd12);
    im[11] = ls(0, 0, 0, 7, 12'd16);
    start();
    step(20);
    chk(dm[0], 32'd255, "R3 add");
    chk(dm[1], 32'd145, "R3 sub");
    chk(dm[2], 32'd8, "R3 and imm");
    chk(dm[3], 32'hFF, "R3 orr");
    chk(dm[4], 32'hFFFF_FF6F, "R3 sub wrap");
    chk(dm[5], 32'hA5A5_A5A5, "R7 no stray store");
  endtask

  task automatic t_ldst();
    clear_mem();
    dm[5] = 32'hDEAD_BEEF;
    dm[6] = 32'h1234_5678;
    im[0] = dp(MOV_, 1, 0, 1, 8'd20);
    im[1] = ls(1, 0, 1, 2, 12'd0);
    im[2] = dp(MOV_, 1, 0, 3, 8'd4);
    im[3] = ls(1, 1, 1, 4, 12'd3);
    im[4] = dp(MOV_, 1, 0, 5, 8'd8);
    im[5] = ls(0, 1, 1, 2, 12'd5);
    im[6] = ls(0, 0, 0, 4, 12'd40);
    im[7] = ls(0, 0, 0, 7, 12'd44);
    start();
    step(20);
    chk(dm[7], 32'hDEAD_BEEF, "R6 ldr imm / R7 str reg offset");
    chk(dm[10], 32'h1234_5678, "R6 ldr reg offset / R7 str imm");
    chk(dm[11], 32'h0, "R2 registers cleared by reset");
    chk(dm[6], 32'h1234_5678, "R6 load leaves memory");
  endtask

  task automatic t_branch();
    clear_mem();
    im[0]  = dp(MOV_, 1, 0, 1, 8'd1);
    im[1]  = br(0, 24'd2);
    im[2]  = dp(MOV_, 1, 0, 1, 8'd99);
    im[3]  = dp(MOV_, 1, 0, 1, 8'd98);
    im[4]  = dp(MOV_, 1, 0, 1, 8'd97);
    im[5]  = ls(0, 0, 0, 1, 12'd0);
    im[6]  = br(1, 24'd2);
    im[7]  = dp(MOV_, 1, 0, 1, 8'd96);
    im[10] = ls(0, 0, 0, 14, 12'd4);
    im[11] = dp(MOV_, 0, 0, 2, 8'h0F);
    im[12] = ls(0, 0, 0, 2, 12'd8);
    start();
    step(2);
    chk(imem_addr, 32'd20, "R8 forward branch target");
    step(2);
    chk(imem_addr, 32'd40, "R9 bl target");
    step(8);
    chk(imem_addr, 32'd52, "R8 backward branch to self");
    chk(dm[0], 32'd1, "R8 skipped instructions");
    chk(dm[1], 32'd28, "R9 link value");
    chk(dm[2], 32'd52, "R5 r15 reads pc+8");
  endtask

  task automatic t_flags();
    clear_mem();
    dm[0] = 32'h8000_0000;
    im[0] = dp(MOV_, 1, 0, 1, 8'd5);
    im[1] = dp(CMP_, 1, 1, 1, 8'd5);
    im[2] = dp(CMP_, 1, 1, 1, 8'd6);
    im[3] = dp(MOV_, 1, 0, 2, 8'd7);
    im[4] = ls(1, 0, 0, 3, 12'd0);
    im[5] = dp(CMP_, 1, 3, 3, 8'd1);
    im[6] = dp(ADD_, 0, 1, 4, 8'd1);
    im[7] = ls(0, 0, 0, 4, 12'd4);
    im[8] = ls(0, 0, 0, 1, 12'd8);
    start();
    step(2);
    chk({28'b0, nzcv}, 32'b0110, "R4 cmp equal");
    step(1);
    chk({28'b0, nzcv}, 32'b1000, "R4 cmp negative");
    step(1);
    chk({28'b0, nzcv}, 32'b1000, "R4 mov keeps flags");
    step(2);
    chk({28'b0, nzcv}, 32'b0011, "R4 cmp overflow");
    step(1);
    chk({28'b0, nzcv}, 32'b0011, "R4 add keeps flags");
    step(6);
    chk(dm[1], 32'd10, "R3 add reg");
    chk(dm[2], 32'd5, "R4 cmp writes no register");
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_ldst();
    t_branch();
    t_flags();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule